// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block is the part of a host bridge that decides where accesses to the legacy region below 1 MiB go. Software programs it through byte-lane configuration writes: a dword-aligned offset, 32 bits of data and four byte enables. It holds a bank of seven attribute bytes and one control byte for system-management RAM. The seven attribute bytes are shared by thirteen shadowable windows: the top 64 KiB BIOS window and twelve 16 KiB expansion windows.

For every memory access presented on its decode inputs, the block returns one routing decision, combinationally from the stored registers. An access can go to DRAM, to PCI, or to SMRAM. The decision uses the address, a flag that marks a system-management-mode access, and a flag that separates writes from reads. Reads of the configuration space return the attribute bytes, the SMRAM control byte and a read-only byte that reports the memory size.

Top module: `mem_attr_decoder`

## Requirements
- R1: After reset every attribute byte reads 0x00 and the SMRAM control byte at offset 0x72 reads 0x02. Bytes the block does not own read 0x00.
- R2: The byte at offset 0x57 is read-only and reads min(255, TOTAL_MEM_MIB / 8). With the default of 4096 MiB it reads 0xFF, and writes to it change nothing.
- R3: Window 0 covers 0xF0000 to 0xFFFFF and uses the high nibble of the byte at 0x59. Window i, for i from 1 to 12, covers 16 KiB starting at 0xC0000 + (i-1)*0x4000 and uses the byte at 0x59 + ceil(i/2). An odd i uses the low nibble of that byte and an even i uses the high nibble.
- R4: In a window's nibble, bit 0 enables reads and bit 1 enables writes. A read goes to DRAM when bit 0 is 1 and to PCI otherwise. A write goes to DRAM when bit 1 is 1 and to PCI otherwise. The route code is 0 for DRAM, 1 for PCI and 2 for SMRAM.
- R5: A configuration write stores only the enabled lanes that fall on offsets 0x59 to 0x5F or on 0x72. Lane n of a write at offset A is byte A+n. A write that covers none of these bytes leaves every route and every readback unchanged.
- R6: An access without the SMM flag to 0xA0000 to 0xBFFFF goes to DRAM when the open bit (bit 6 of 0x72) is 1, and to PCI when it is 0.
- R7: An access with the SMM flag to 0xA0000 to 0xBFFFF goes to SMRAM when the global enable bit (bit 3 of 0x72) is 1, and to PCI otherwise. Route code 2 never appears without the SMM flag.
- R8: Writing 1 to the lock bit (bit 4 of 0x72) sets it until reset. While the lock is set, and in the same write that sets it, the open bit reads 0 and the window is treated as closed. While locked, writes to bits 6 and 4 are ignored and the other bits stay writable.
- R9: Accesses below 0xA0000 always go to DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset (bits 1:0 ignored) |
| cfg_be_i | input | 4 | Byte-lane enables for the write |
| cfg_wdata_i | input | 32 | Write data, lane n in bits 8n+7:8n |
| cfg_rdata_o | output | 32 | Read data for the dword at cfg_addr_i |
| mem_addr_i | input | 20 | Access address below 1 MiB |
| mem_smm_i | input | 1 | Access issued in system-management mode |
| mem_write_i | input | 1 | Access is a write (0 = read) |
| route_o | output | 2 | Route code: 0 DRAM, 1 PCI, 2 SMRAM |

## Verification
The assertions take for granted that the reset is released away from a clock edge and that the configuration inputs are stable around each rising edge. Write strobes must come with defined lanes and data, and the decode inputs must carry known values whenever they are sampled. The bench drives every input on the falling edge and leaves the write strobe high for exactly one rising edge. It keeps the decode inputs at known addresses inside the 20-bit space, so the one-hot window and stability properties only ever see defined values.

// File: rtl/mad_pkg.sv
package mad_pkg;
  typedef enum logic [1:0] {
    ROUTE_DRAM  = 2'd0,
    ROUTE_PCI   = 2'd1,
    ROUTE_SMRAM = 2'd2
  } route_e;

  localparam logic [7:0] ATTR_BASE  = 8'h59;
  localparam int         ATTR_BYTES = 7;
  localparam logic [7:0] ATTR_END   = 8'(ATTR_BASE + ATTR_BYTES);
  localparam logic [7:0] SMC_OFF    = 8'h72;
  localparam logic [7:0] SMC_RESET  = 8'h02;
  localparam logic [7:0] MSZ_OFF    = 8'h57;

  localparam int BIT_OPEN = 6;
  localparam int BIT_LOCK = 4;
  localparam int BIT_GEN  = 3;
endpackage

// File: rtl/attr_bank.sv
module attr_bank #(
  parameter logic [7:0] BASE   = 8'h59,
  parameter int         NBYTES = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [5:0]            dword_i,
  input  logic [3:0]            be_i,
  input  logic [31:0]           wdata_i,
  output logic [NBYTES*8-1:0]   bank_o
);
  logic [NBYTES-1:0] hit;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    localparam logic [7:0] OFF = 8'(BASE + k);
    assign hit[k] = we_i && (dword_i == OFF[7:2]) && be_i[OFF[1:0]];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bank_o[k*8 +: 8] <= 8'h00;
      else if (hit[k]) bank_o[k*8 +: 8] <= wdata_i[OFF[1:0]*8 +: 8];
    end
  end

  // R5: bank only moves on a write that lands on one of its bytes
  assert_bank_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (dword_i >= BASE[7:2]) && (dword_i <= 6'((BASE + NBYTES - 1) >> 2)))
      |=> $stable(bank_o));
endmodule

// File: rtl/smram_ctl.sv
module smram_ctl #(
  parameter logic [7:0] RESET_VAL = 8'h02,
  parameter int         OPEN_B    = 6,
  parameter int         LOCK_B    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wbyte_i,
  output logic [7:0] ctl_o
);
  logic [7:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we_i) begin
      ctl_d         = wbyte_i;
      ctl_d[LOCK_B] = ctl_q[LOCK_B] | wbyte_i[LOCK_B];
      ctl_d[OPEN_B] = wbyte_i[OPEN_B] & ~ctl_d[LOCK_B];
      if (ctl_q[LOCK_B]) ctl_d[OPEN_B] = ctl_q[OPEN_B];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= RESET_VAL;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[LOCK_B] |=> ctl_q[LOCK_B]);

  assert_lock_blocks_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[LOCK_B] && we_i && wbyte_i[OPEN_B]) |=> !ctl_o[OPEN_B]);
endmodule

// File: rtl/route_decode.sv
module route_decode
  import mad_pkg::*;
#(
  parameter int AW         = 20,
  parameter int NBYTES     = 7,
  parameter int NWIN       = 13,
  parameter int BIOS_BASE  = 'hF0000,
  parameter int BIOS_LOG2  = 16,
  parameter int EXP_BASE   = 'hC0000,
  parameter int EXP_LOG2   = 14,
  parameter int SMR_BASE   = 'hA0000,
  parameter int SMR_LOG2   = 17
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                smm_i,
  input  logic                write_i,
  input  logic [NBYTES*8-1:0] bank_i,
  input  logic [7:0]          smc_i,
  output route_e              route_o
);
  localparam logic [AW-1:0] SMR_A = AW'(SMR_BASE);

  logic [NWIN-1:0] win_hit, win_en;
  logic            smr_hit, any_en;
  logic            unused_bits;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int              LOG2 = (i == 0) ? BIOS_LOG2 : EXP_LOG2;
    localparam logic [AW-1:0]   WB   = AW'((i == 0) ? BIOS_BASE
                                           : EXP_BASE + (i - 1) * (1 << EXP_LOG2));
    localparam int              BI   = (i + 1) / 2;
    localparam int              SH   = (i % 2 == 0) ? 4 : 0;
    logic [1:0] nib;
    assign nib        = bank_i[BI*8 + SH +: 2];
    assign win_hit[i] = (addr_i >> LOG2) == (WB >> LOG2);
    assign win_en[i]  = win_hit[i] & (write_i ? nib[1] : nib[0]);
  end

  assign unused_bits = ^bank_i;
  assign smr_hit     = (addr_i >> SMR_LOG2) == (SMR_A >> SMR_LOG2);
  assign any_en      = |win_en;

  always_comb begin
    if (smr_hit) begin
      if (smm_i)               route_o = smc_i[BIT_GEN]  ? ROUTE_SMRAM : ROUTE_PCI;
      else                     route_o = smc_i[BIT_OPEN] ? ROUTE_DRAM  : ROUTE_PCI;
    end else if (|win_hit)     route_o = any_en ? ROUTE_DRAM : ROUTE_PCI;
    else                       route_o = ROUTE_DRAM;
  end

  assert_win_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_hit));

  assert_smram_needs_smm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_o == ROUTE_SMRAM) |-> smm_i);

  assert_low_is_dram_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < SMR_A) |-> (route_o == ROUTE_DRAM));
endmodule

// File: rtl/mem_attr_decoder.sv
module mem_attr_decoder
  import mad_pkg::*;
#(
  parameter int TOTAL_MEM_MIB = 4096,
  parameter int AW            = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_addr_i,
  input  logic [3:0]    cfg_be_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic [AW-1:0] mem_addr_i,
  input  logic          mem_smm_i,
  input  logic          mem_write_i,
  output logic [1:0]    route_o
);
  localparam int         MEM_UNITS = TOTAL_MEM_MIB / 8;
  localparam logic [7:0] MEM_BYTE  = (MEM_UNITS > 255) ? 8'hFF : 8'(MEM_UNITS);
  localparam logic [1:0] SMC_LANE  = SMC_OFF[1:0];

  logic [ATTR_BYTES*8-1:0] bank;
  logic [7:0]              smc;
  logic                    smc_we;
  route_e                  route;

  attr_bank #(.BASE(ATTR_BASE), .NBYTES(ATTR_BYTES)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .dword_i (cfg_addr_i[7:2]),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .bank_o  (bank)
  );

  assign smc_we = cfg_we_i && (cfg_addr_i[7:2] == SMC_OFF[7:2]) && cfg_be_i[SMC_LANE];

  smram_ctl #(.RESET_VAL(SMC_RESET), .OPEN_B(BIT_OPEN), .LOCK_B(BIT_LOCK)) u_smc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (smc_we),
    .wbyte_i (cfg_wdata_i[SMC_LANE*8 +: 8]),
    .ctl_o   (smc)
  );

  route_decode #(.AW(AW), .NBYTES(ATTR_BYTES)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (mem_addr_i),
    .smm_i   (mem_smm_i),
    .write_i (mem_write_i),
    .bank_i  (bank),
    .smc_i   (smc),
    .route_o (route)
  );

  assign route_o = route;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] off;
    assign off = {cfg_addr_i[7:2], 2'(l)};
    always_comb begin
      if (off >= ATTR_BASE && off < ATTR_END)
        cfg_rdata_o[l*8 +: 8] = bank[int'(off - ATTR_BASE)*8 +: 8];
      else if (off == SMC_OFF) cfg_rdata_o[l*8 +: 8] = smc;
      else if (off == MSZ_OFF) cfg_rdata_o[l*8 +: 8] = MEM_BYTE;
      else                     cfg_rdata_o[l*8 +: 8] = 8'h00;
    end
  end
endmodule

// File: tb/tb_mem_attr_decoder.sv
module tb_mem_attr_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = 8'h00;
  logic [3:0]  cfg_be_i = 4'h0;
  logic [31:0] cfg_wdata_i = 32'h0;
  logic [31:0] cfg_rdata_o;
  logic [19:0] mem_addr_i = 20'h0;
  logic        mem_smm_i = 1'b0;
  logic        mem_write_i = 1'b0;
  logic [1:0]  route_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_bank [7];

  localparam logic [1:0] DRAM = 2'd0, PCI = 2'd1, SMR = 2'd2;

  always #10 clk = ~clk;

  mem_attr_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .mem_addr_i(mem_addr_i), .mem_smm_i(mem_smm_i), .mem_write_i(mem_write_i),
    .route_o(route_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 7; k++) exp_bank[k] = 8'h00;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
    for (int l = 0; l < 4; l++) begin
      int off;
      off = int'({a[7:2], 2'b00}) + l;
      if (be[l] && off >= 'h59 && off <= 'h5F) exp_bank[off - 'h59] = d[l*8 +: 8];
    end
    @(negedge clk);
    cfg_we_i = 1'b0; cfg_be_i = 4'h0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    cfg_addr_i = a;
    #1;
    chk(tag, cfg_rdata_o, exp);
  endtask

  task automatic rt_chk(input string tag, input logic [19:0] a, input logic smm,
                        input logic wr, input logic [1:0] exp);
    mem_addr_i = a; mem_smm_i = smm; mem_write_i = wr;
    #1;
    chk($sformatf("%s addr=%h smm=%0b wr=%0b", tag, a, smm, wr), 32'(route_o), 32'(exp));
  endtask

  function automatic logic [1:0] win_exp(input int w, input logic wr);
    int bi;
    logic [3:0] nib;
    bi  = (w + 1) / 2;
    nib = (w % 2 == 0) ? exp_bank[bi][7:4] : exp_bank[bi][3:0];
    return (wr ? nib[1] : nib[0]) ? DRAM : PCI;
  endfunction

  // R3 R4: sweep all windows at both edges, reads and writes
  task automatic sweep_windows(input string tag);
    for (int w = 0; w < 13; w++) begin
      logic [19:0] base, last;
      base = (w == 0) ? 20'hF0000 : 20'(32'hC0000 + (w - 1) * 32'h4000);
      last = (w == 0) ? 20'hFFFFF : 20'(base + 20'h3FFF);
      for (int wr = 0; wr < 2; wr++) begin
        rt_chk({tag, " R3 R4"}, base, 1'b0, wr[0], win_exp(w, wr[0]));
        rt_chk({tag, " R3 R4"}, last, 1'b0, wr[0], win_exp(w, wr[0]));
      end
    end
  endtask

  task automatic t_reset();
    rd_chk("R1 smram ctl reset", 8'h70, 32'h0002_0000);
    rd_chk("R1 attr reset lo", 8'h58, 32'h0);
    rd_chk("R1 attr reset hi", 8'h5C, 32'h0);
    rd_chk("R1 unowned dword", 8'h40, 32'h0);
    rt_chk("R1 bios after reset", 20'hF0000, 1'b0, 1'b0, PCI);
    rt_chk("R1 smram after reset", 20'hA0000, 1'b0, 1'b0, PCI);
  endtask

  task automatic t_memsize();
    // 4096 MiB / 8 = 512, saturates to 255
    rd_chk("R2 mem size", 8'h54, 32'hFF00_0000);
    cfg_write(8'h54, 4'hF, 32'h1234_5678);
    rd_chk("R2 mem size after write", 8'h54, 32'hFF00_0000);
  endtask

  task automatic t_pattern_a();
    cfg_write(8'h58, 4'b1110, 32'h3221_1AFF);
    cfg_write(8'h5C, 4'b1111, 32'h3103_2013);
    rd_chk("R5 readback 58", 8'h58, 32'h3221_1A00);
    rd_chk("R5 readback 5C", 8'h5C, 32'h3103_2013);
    sweep_windows("patA");
  endtask

  task automatic t_partial_be();
    cfg_write(8'h5C, 4'b0101, 32'h3333_3333);
    rd_chk("R5 partial lanes", 8'h5C, 32'h3133_2033);
    sweep_windows("patB");
  endtask

  task automatic t_other_writes();
    cfg_write(8'h54, 4'hF, 32'hFFFF_FFFF);
    cfg_write(8'h60, 4'hF, 32'hFFFF_FFFF);
    cfg_write(8'h70, 4'b1011, 32'hFFFF_FFFF);
    rd_chk("R5 58 unchanged", 8'h58, 32'h3221_1A00);
    rd_chk("R5 5C unchanged", 8'h5C, 32'h3133_2033);
    rd_chk("R5 smram unchanged", 8'h70, 32'h0002_0000);
    sweep_windows("other");
  endtask

  task automatic t_low_dram();
    rt_chk("R9 zero", 20'h00000, 1'b0, 1'b0, DRAM);
    rt_chk("R9 top of low", 20'h9FFFF, 1'b1, 1'b1, DRAM);
    rt_chk("R9 mid", 20'h4_1234, 1'b0, 1'b1, DRAM);
  endtask

  task automatic t_smram();
    rt_chk("R6 closed", 20'hA0000, 1'b0, 1'b0, PCI);
    rt_chk("R7 gen off", 20'hA0000, 1'b1, 1'b0, PCI);
    cfg_write(8'h70, 4'b0100, 32'h0040_0000);
    rt_chk("R6 open", 20'hBFFFF, 1'b0, 1'b1, DRAM);
    rt_chk("R7 open gen off", 20'hBFFFF, 1'b1, 1'b0, PCI);
    cfg_write(8'h70, 4'b0100, 32'h0008_0000);
    rt_chk("R6 closed gen on", 20'hA8000, 1'b0, 1'b0, PCI);
    rt_chk("R7 gen on", 20'hA8000, 1'b1, 1'b0, SMR);
    cfg_write(8'h70, 4'b0100, 32'h0048_0000);
    rt_chk("R6 open gen on", 20'hB0000, 1'b0, 1'b0, DRAM);
    rt_chk("R7 open gen on", 20'hB0000, 1'b1, 1'b1, SMR);
    rd_chk("R6 readback", 8'h70, 32'h0048_0000);
  endtask

  task automatic t_lock();
    cfg_write(8'h70, 4'b0100, 32'h0050_0000);
    rd_chk("R8 lock forces open 0", 8'h70, 32'h0010_0000);
    rt_chk("R8 locked closed", 20'hA0000, 1'b0, 1'b0, PCI);
    cfg_write(8'h70, 4'b0100, 32'h0048_0000);
    rd_chk("R8 open ignored gen kept", 8'h70, 32'h0018_0000);
    rt_chk("R8 locked non-smm", 20'hA0000, 1'b0, 1'b0, PCI);
    rt_chk("R8 locked smm gen", 20'hA0000, 1'b1, 1'b0, SMR);
    cfg_write(8'h70, 4'b0100, 32'h0000_0000);
    rd_chk("R8 lock sticky", 8'h70, 32'h0010_0000);
    rt_chk("R8 gen cleared", 20'hA0000, 1'b1, 1'b0, PCI);
    do_reset();
    rd_chk("R8 R1 lock cleared by reset", 8'h70, 32'h0002_0000);
    cfg_write(8'h70, 4'b0100, 32'h0040_0000);
    rt_chk("R8 open after reset", 20'hA0000, 1'b0, 1'b0, DRAM);
    sweep_windows("reset");
  endtask

  initial begin
    for (int k = 0; k < 7; k++) exp_bank[k] = 8'h00;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_memsize();
    t_pattern_a();
    t_partial_be();
    t_other_writes();
    t_low_dram();
    t_smram();
    t_lock();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule